// File: doc/BRIEF.md
# Dual-Reload Down-Counting PWM Timer

This block is a single timer channel that produces a pulse-width-modulated output from two independently programmed phase widths. A down-counter runs at the input clock. In pulse-width mode each time the counter reaches zero the output flips and the counter reloads from whichever count belongs to the phase that is starting. One count gives the low phase and the other gives the high phase, so period and duty are set separately. With the pulse-width bit clear, only the low-phase count is used and the output is a square wave with equal halves.

Software reaches the channel through a small word-addressed register port. Word 0 is the control register, word 1 is the low-phase count and word 2 is the high-phase count. The expected flow is to disable the timer, program the counts, then enable it. The enable edge copies the low-phase count into the counter and starts the output low. With the reload bit clear the counter wraps to all ones at zero instead of reloading. This free-running variant exists for completeness of the control register.

Top module: `pwm_reload_timer`

## Requirements
- R1: Every phase lasts (count + 1) input clock cycles, so a count of 0 gives a one-cycle phase.
- R2: In pulse-width mode the low phase uses the word-1 count and the high phase uses the word-2 count. After the enable edge the output starts in the low phase.
- R3: Both load counts are CNT_W (default 32) bits wide and read back exactly as written.
- R4: Control word bit 0 is the run enable, bit 1 selects reload-from-count at zero, and bit 2 selects pulse-width mode. Those three bits read back as written and all higher bits read as zero.
- R5: With bit 1 clear, the counter wraps to all ones on reaching zero and the output still flips there. The first phase after enable still lasts word-1 count + 1 cycles.
- R6: With bit 2 clear and bit 1 set, the output is a square wave. Both halves last word-1 count + 1 cycles and the word-2 count has no effect.
- R7: Clearing the run bit drives the output low at once and freezes the counter. Setting it again restarts with a full low phase taken from word 1.
- R8: A write to a load count during a running phase does not change that phase. The new value is used at the next reload that selects it.
- R9: Reset clears the control word, both counts, the counter and the output.
- R10: Word 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the counter steps once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Word address: 0 control, 1 low count, 2 high count, 3 unused |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | Registered timer output |

## Verification
The hardest case to reach from the ports is a load-count write that lands inside the phase using that same count. The stimulus enables the timer with a long low phase and a short high phase. A concurrent thread then rewrites the low count three cycles into the low phase, while a sampler measures every run length of the output. The first low run must keep its old width, and the following low run must take the new one. Free-running mode is checked through the one observable effect: with a 32-bit wrap, the phase after the first one stays unchanged for far longer than any programmed count.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int unsigned REG_AW = 2;
  localparam int unsigned CTRL_W = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 2'd0,
    RA_LOW  = 2'd1,
    RA_HIGH = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // bit 2 pulse-width mode, bit 1 reload at zero, bit 0 run
  typedef struct packed {
    logic pwm;
    logic reload;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  output ctrl_t                ctrl,
  output logic [CNT_W-1:0]     ld_low,
  output logic [CNT_W-1:0]     ld_high,
  output logic                 start,
  output logic                 stop
);

  localparam int unsigned PAD_W = CNT_W - CTRL_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] low_q, low_d;
  logic [CNT_W-1:0] high_q, high_d;
  logic             wr_any, wr_ctrl, wr_low, wr_high;
  ctrl_t            wr_ctrl_val;

  assign wr_any      = bus_sel & bus_wr;
  assign wr_ctrl     = wr_any & (bus_addr == RA_CTRL);
  assign wr_low      = wr_any & (bus_addr == RA_LOW);
  assign wr_high     = wr_any & (bus_addr == RA_HIGH);
  assign wr_ctrl_val = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  // run-bit edges seen by the sequencer
  assign start = wr_ctrl &  wr_ctrl_val.run & ~ctrl_q.run;
  assign stop  = wr_ctrl & ~wr_ctrl_val.run &  ctrl_q.run;

  always_comb begin
    ctrl_d = ctrl_q;
    low_d  = low_q;
    high_d = high_q;
    if (wr_ctrl) ctrl_d = wr_ctrl_val;
    if (wr_low)  low_d  = bus_wdata;
    if (wr_high) high_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_low)  low_q  <= low_d;
      if (wr_high) high_q <= high_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
      RA_LOW:  bus_rdata = low_q;
      RA_HIGH: bus_rdata = high_q;
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign ld_low  = low_q;
  assign ld_high = high_q;

  // R3: a written low count is held exactly
  a_r3_low_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low |=> (low_q == $past(bus_wdata)));

  // R10: writes to the spare word leave every register alone
  a_r10_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == RA_NONE) |=>
      ($stable(ctrl_q) && $stable(low_q) && $stable(high_q)));

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_zero = (cnt_q == '0);

  // R1: a reload presents the sequencer's chosen value next cycle
  a_r1_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R7: without load or step the count is frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_tmr_seq.sv
module pwm_tmr_seq #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             stop,
  input  logic             reload_mode,
  input  logic             pwm_mode,
  input  logic [CNT_W-1:0] ld_low,
  input  logic [CNT_W-1:0] ld_high,
  input  logic             at_zero,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             dec,
  output logic             pwm_out
);

  logic out_q, out_d;
  logic wrap;

  // terminal count while running and not being stopped
  assign wrap = run & at_zero & ~stop;
  assign load = start | wrap;
  assign dec  = run & ~at_zero & ~stop;

  always_comb begin
    if (start)                     load_val = ld_low;
    else if (!reload_mode)         load_val = '1;
    else if (pwm_mode && !out_q)   load_val = ld_high;
    else                           load_val = ld_low;
  end

  always_comb begin
    out_d = out_q;
    if (start || stop) out_d = 1'b0;
    else if (wrap)     out_d = ~out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;

  // R7: a stopped timer drives low
  a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !out_q);

  // R2: the enable edge begins a low phase
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_q);

  // R1: each terminal count flips the output
  a_r1_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (out_q != $past(out_q)));

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             pwm_out
);

  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_N-1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] ld_low, ld_high, load_val, cnt;
  logic             start, stop, load, dec, at_zero;

  pwm_tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl),
    .ld_low    (ld_low),
    .ld_high   (ld_high),
    .start     (start),
    .stop      (stop)
  );

  pwm_tmr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .run         (ctrl.run),
    .start       (start),
    .stop        (stop),
    .reload_mode (ctrl.reload),
    .pwm_mode    (ctrl.pwm),
    .ld_low      (ld_low),
    .ld_high     (ld_high),
    .at_zero     (at_zero),
    .load        (load),
    .load_val    (load_val),
    .dec         (dec),
    .pwm_out     (pwm_out)
  );

  pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .cnt      (cnt),
    .at_zero  (at_zero)
  );

  // R9: while reset is held inside, the output stays low
  a_r9_reset_low: assert property (@(posedge clk)
    !rst_core_n |=> (!pwm_out || !rst_core_n));

endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_wr;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int runs [0:7];
  logic first_lvl;

  always #10 clk = ~clk;

  pwm_reload_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sample_runs(input int n, input int cap);
    logic cur;
    int len;
    int idx;
    first_lvl = pwm_out; cur = pwm_out; len = 1; idx = 0;
    while (idx < n) begin
      @(negedge clk);
      if (pwm_out == cur && len < cap) len++;
      else begin runs[idx] = len; idx++; cur = pwm_out; len = 1; end
    end
  endtask

  task automatic t_reset_state();
    logic [W-1:0] d;
    rd(2'd0, d); check("R9 ctrl after reset", d, 0);
    rd(2'd1, d); check("R9 low count after reset", d, 0);
    rd(2'd2, d); check("R9 high count after reset", d, 0);
    check("R9 output after reset", pwm_out, 0);
  endtask

  task automatic t_pwm_basic();
    wr(2'd1, 3); wr(2'd2, 6); wr(2'd0, 7);
    sample_runs(4, 100);
    check("R2 starts low", first_lvl, 0);
    check("R1 R2 low run 1", runs[0], 4);
    check("R1 R2 high run 1", runs[1], 7);
    check("R2 low run 2", runs[2], 4);
    check("R2 high run 2", runs[3], 7);
  endtask

  task automatic t_disable_restart();
    logic [W-1:0] d;
    int highs;
    repeat (5) @(negedge clk);
    wr(2'd0, 0);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check("R7 output low while stopped", highs, 0);
    rd(2'd0, d); check("R7 ctrl reads stopped", d, 0);
    wr(2'd0, 7);
    sample_runs(2, 100);
    check("R7 restart begins low", first_lvl, 0);
    check("R7 restart full low phase", runs[0], 4);
    check("R7 restart high phase", runs[1], 7);
  endtask

  task automatic t_square();
    wr(2'd0, 0); wr(2'd1, 5); wr(2'd2, 1); wr(2'd0, 3);
    sample_runs(3, 100);
    check("R6 square starts low", first_lvl, 0);
    check("R6 square half 1", runs[0], 6);
    check("R6 square half 2 ignores high count", runs[1], 6);
    check("R6 square half 3", runs[2], 6);
  endtask

  task automatic t_min_counts();
    wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 7);
    sample_runs(4, 100);
    check("R1 zero count low", runs[0], 1);
    check("R1 zero count high", runs[1], 1);
    check("R1 zero count low again", runs[2], 1);
    check("R1 zero count high again", runs[3], 1);
  endtask

  task automatic t_mid_write();
    wr(2'd0, 0); wr(2'd1, 9); wr(2'd2, 2); wr(2'd0, 7);
    fork
      sample_runs(3, 100);
      begin
        repeat (3) @(negedge clk);
        wr(2'd1, 1);
      end
    join
    check("R8 low phase in progress kept", runs[0], 10);
    check("R8 high phase", runs[1], 3);
    check("R8 new low count at next reload", runs[2], 2);
  endtask

  task automatic t_free_run();
    wr(2'd0, 0); wr(2'd1, 2); wr(2'd0, 5);
    sample_runs(2, 40);
    check("R5 first phase from low count", runs[0], 3);
    check("R5 wrapped phase long", runs[1], 40);
    check("R5 output flipped at zero", pwm_out, 1);
  endtask

  task automatic t_regs();
    logic [W-1:0] d;
    wr(2'd0, 0);
    wr(2'd1, 32'hA5C3_0F81); rd(2'd1, d); check("R3 low count full width", d, 32'hA5C3_0F81);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R3 high count full width", d, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFA); rd(2'd0, d); check("R4 ctrl upper bits zero", d, 2);
    wr(2'd3, 32'h0000_0007); rd(2'd3, d); check("R10 spare word reads zero", d, 0);
    rd(2'd0, d); check("R10 spare write leaves ctrl", d, 2);
    rd(2'd1, d); check("R10 spare write leaves low", d, 32'hA5C3_0F81);
    check("R4 run bit clear keeps output low", pwm_out, 0);
  endtask

  task automatic t_reset_midrun();
    logic [W-1:0] d;
    wr(2'd1, 4); wr(2'd2, 4); wr(2'd0, 7);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 output cleared by reset", pwm_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R9 ctrl cleared", d, 0);
    rd(2'd2, d); check("R9 high count cleared", d, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_pwm_basic();
    t_disable_restart();
    t_square();
    t_min_counts();
    t_mid_write();
    t_free_run();
    t_regs();
    t_reset_midrun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule